// File: doc/BRIEF.md
# Access Order Protection Unit

This unit sits between the memory port of a pipelined processor and the single shared memory/peripheral bus. The pipeline can present a write and the read that follows it in program order in the same cycle. For ordinary memory the unit lets the read go out first, because the load result is needed sooner. Some address windows hold peripheral registers or an external device, where a read after a write must see the write's effect. For those windows the unit keeps program order and spends extra stall cycles to separate the two accesses.

Three address windows are decoded: two peripheral register frames and one external bus zone. A window is described by a base and a mask, both set as parameters. A per-window enable register selects which windows are protected. Every window is protected out of reset, and the register can be rewritten at any time through a one-cycle load strobe. A write/read pair counts as protected when either of its two addresses falls in an enabled window. A read to the same address as the write it follows is always ordered after that write. While it stalls, the unit expects the pipeline to hold both requests unchanged. The held requests count as consumed in the first cycle that `stall` is low.

Top module: `access_order_unit`

## Requirements
- R1: While `rst_n` is low, `bus_valid` and `stall` are low. After reset every window enable bit is 1.
- R2: A lone write (`wr_valid` without `rd_valid`) or a lone read is placed on the bus in the same cycle, with `stall` low. A write appears with `bus_we`=1, its address and its data. A read appears with `bus_we`=0 and its address.
- R3: For a pair with different addresses and no protected address, the read goes on the bus in the pair's first cycle with `stall`=1. The write follows in the next cycle with `stall`=0.
- R4: For a protected pair, the write goes on the bus in the first cycle. `GAP_CYCLES` cycles with no bus request follow, then the read. `stall` is high for the first 1+`GAP_CYCLES` cycles and low in the read's cycle.
- R5: For an unprotected pair whose two addresses are equal, the write goes out in the first cycle with `stall`=1. The read follows in the next cycle with `stall`=0 and no gap.
- R6: Window i is hit when `(addr & ~MASK_i) == BASE_i`. The default windows are 0x000800–0x000FFF (i=0), 0x007000–0x007FFF (i=1) and 0x004000–0x005FFF (i=2). A pair is protected when either of its addresses hits a window whose enable bit is 1.
- R7: A cycle with `cfg_wr`=1 loads `cfg_en` into the enable register (bit i controls window i). The new value applies from the next cycle. A pair whose hits all lie in disabled windows is handled as unprotected.
- R8: The unit puts at most one request on the bus per cycle. The first cycle of every pair has `stall` high. A write issued while stalling is never followed directly by another write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request present (younger than a same-cycle write) |
| rd_addr | input | ADDR_W | Read address |
| cfg_wr | input | 1 | Load strobe for the window enable register |
| cfg_en | input | NUM_REGIONS | New window enable bits |
| bus_valid | output | 1 | Bus request this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| stall | output | 1 | Pipeline must hold its requests |

## Verification
The hardest case is a pair in which only the read address lies in an enabled window while the write address lies outside every window. In that case protection depends on the read side of the decode alone. A second hard case is a pair sent right after the enable register has switched off the very window it hits. Directed steps build both cases. Random pairs are then drawn from a pool weighted towards window addresses and repeated addresses, and the enable register is rewritten at random points. Every cycle the bench records the bus stream and the stall count, and compares them with a sequence its own model builds from the rules above.

// File: rtl/access_order_pkg.sv
package access_order_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_LATE = 2'd1,
        ST_GAP     = 2'd2,
        ST_RD_LATE = 2'd3
    } order_state_t;

endpackage

// File: rtl/aop_region_decode.sv
module aop_region_decode #(
    parameter int ADDR_W      = 22,
    parameter int NUM_REGIONS = 3,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE = '0,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_MASK = '0
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic [NUM_REGIONS-1:0] hit
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE = REGION_BASE[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] MASK = REGION_MASK[g*ADDR_W +: ADDR_W];
        assign hit[g] = ((addr & ~MASK) == BASE);
    end

endmodule

// File: rtl/aop_prot_reg.sv
module aop_prot_reg #(
    parameter int NUM_REGIONS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [NUM_REGIONS-1:0] cfg_en,
    output logic [NUM_REGIONS-1:0] en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (cfg_wr) begin
            en_q <= cfg_en;
        end
    end

endmodule

// File: rtl/aop_order_fsm.sv
module aop_order_fsm
    import access_order_pkg::*;
#(
    parameter int ADDR_W     = 22,
    parameter int DATA_W     = 16,
    parameter int GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pair_prot,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              stall
);

    localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);

    order_state_t     state_q, state_d;
    logic [CNT_W-1:0] gap_q, gap_d;
    logic             pair, same_addr;

    assign pair      = wr_valid && rd_valid;
    assign same_addr = (wr_addr == rd_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            gap_q   <= gap_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pair) begin
                    if (pair_prot) begin
                        state_d = ST_GAP;
                        gap_d   = GAP_LOAD;
                    end else if (same_addr) begin
                        state_d = ST_RD_LATE;
                    end else begin
                        state_d = ST_WR_LATE;
                    end
                end
            end
            ST_WR_LATE: state_d = ST_IDLE;
            ST_GAP: begin
                if (gap_q == '0) begin
                    state_d = ST_RD_LATE;
                end else begin
                    gap_d = gap_q - 1'b1;
                end
            end
            ST_RD_LATE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        stall     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pair) begin
                    stall     = 1'b1;
                    bus_valid = 1'b1;
                    if (!pair_prot && !same_addr) begin
                        bus_addr = rd_addr;
                    end else begin
                        bus_we    = 1'b1;
                        bus_addr  = wr_addr;
                        bus_wdata = wr_data;
                    end
                end else if (wr_valid) begin
                    bus_valid = 1'b1;
                    bus_we    = 1'b1;
                    bus_addr  = wr_addr;
                    bus_wdata = wr_data;
                end else if (rd_valid) begin
                    bus_valid = 1'b1;
                    bus_addr  = rd_addr;
                end
            end
            ST_WR_LATE: begin
                bus_valid = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = wr_addr;
                bus_wdata = wr_data;
            end
            ST_GAP: stall = 1'b1;
            ST_RD_LATE: begin
                bus_valid = 1'b1;
                bus_addr  = rd_addr;
            end
            default: ;
        endcase
        if (!rst_n) begin
            bus_valid = 1'b0;
            stall     = 1'b0;
        end
    end

endmodule

// File: rtl/access_order_unit.sv
module access_order_unit #(
    parameter int ADDR_W      = 22,
    parameter int DATA_W      = 16,
    parameter int NUM_REGIONS = 3,
    parameter int GAP_CYCLES  = 2,
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE =
        {22'h004000, 22'h007000, 22'h000800},
    parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_MASK =
        {22'h001FFF, 22'h000FFF, 22'h0007FF}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_valid,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic                   cfg_wr,
    input  logic [NUM_REGIONS-1:0] cfg_en,
    output logic                   bus_valid,
    output logic                   bus_we,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      bus_wdata,
    output logic                   stall
);

    logic [NUM_REGIONS-1:0] wr_hit, rd_hit, en_q;
    logic                   pair_prot;

    aop_region_decode #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
        .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK)
    ) i_dec_wr (
        .addr(wr_addr), .hit(wr_hit)
    );

    aop_region_decode #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS),
        .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK)
    ) i_dec_rd (
        .addr(rd_addr), .hit(rd_hit)
    );

    aop_prot_reg #(.NUM_REGIONS(NUM_REGIONS)) i_prot (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .en_q(en_q)
    );

    assign pair_prot = |((wr_hit | rd_hit) & en_q);

    aop_order_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .pair_prot(pair_prot),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .stall(stall)
    );

endmodule

// File: rtl/access_order_unit_chk.sv
module access_order_unit_chk #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              stall
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!bus_valid && !stall)); // R1

    AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_valid && !$past(stall)) |->
        (bus_valid && bus_we && !stall && bus_addr == wr_addr && bus_wdata == wr_data)); // R2

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && stall) |=> (bus_valid && bus_we && !stall)); // R3

    AST_NO_WRITE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && stall) |=> !(bus_valid && bus_we)); // R4

    AST_PAIR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_valid && !$past(stall)) |-> stall); // R8

    AST_HELD_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (wr_valid && rd_valid && $stable(wr_addr) && $stable(rd_addr))); // R8

endmodule

bind access_order_unit access_order_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stall(stall)
);

// File: tb/test_access_order_unit.sv
module test_access_order_unit;

    localparam int AW  = 22;
    localparam int DW  = 16;
    localparam int NR  = 3;
    localparam int GAP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, rd_valid = 1'b0, cfg_wr = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NR-1:0] cfg_en = '0;
    logic          bus_valid, bus_we, stall;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;

    int checks = 0;
    int errors = 0;
    logic [NR-1:0] en_mirror = '1;

    // bench log and expectation
    logic          lg_we   [8];
    logic [AW-1:0] lg_addr [8];
    logic [DW-1:0] lg_data [8];
    int            lg_n, lg_stalls;
    logic          ex_we   [4];
    logic [AW-1:0] ex_addr [4];
    logic [DW-1:0] ex_data [4];
    int            ex_n, ex_stalls;

    always #5 clk = ~clk;

    access_order_unit i_access_order_unit (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stall(stall)
    );

    function automatic logic [NR-1:0] hits(input logic [AW-1:0] a);
        logic [NR-1:0] h;
        h[0] = (a >= 22'h000800 && a <= 22'h000FFF);
        h[1] = (a >= 22'h007000 && a <= 22'h007FFF);
        h[2] = (a >= 22'h004000 && a <= 22'h005FFF);
        return h;
    endfunction

    function automatic logic is_prot(input logic [AW-1:0] wa, input logic [AW-1:0] ra);
        return |((hits(wa) | hits(ra)) & en_mirror);
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_expect(input logic wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                                input logic rv, input logic [AW-1:0] ra);
        ex_n = 0;
        ex_stalls = 0;
        if (wv && rv) begin
            if (is_prot(wa, ra)) begin
                ex_we[0] = 1'b1; ex_addr[0] = wa; ex_data[0] = wd;
                ex_we[1] = 1'b0; ex_addr[1] = ra; ex_data[1] = '0;
                ex_n = 2; ex_stalls = 1 + GAP;
            end else if (wa == ra) begin
                ex_we[0] = 1'b1; ex_addr[0] = wa; ex_data[0] = wd;
                ex_we[1] = 1'b0; ex_addr[1] = ra; ex_data[1] = '0;
                ex_n = 2; ex_stalls = 1;
            end else begin
                ex_we[0] = 1'b0; ex_addr[0] = ra; ex_data[0] = '0;
                ex_we[1] = 1'b1; ex_addr[1] = wa; ex_data[1] = wd;
                ex_n = 2; ex_stalls = 1;
            end
        end else if (wv) begin
            ex_we[0] = 1'b1; ex_addr[0] = wa; ex_data[0] = wd; ex_n = 1;
        end else if (rv) begin
            ex_we[0] = 1'b0; ex_addr[0] = ra; ex_data[0] = '0; ex_n = 1;
        end
    endtask

    // drives at a falling edge, samples 2 ns later each cycle until stall drops
    task automatic run_op(input string req, input logic wv, input logic [AW-1:0] wa,
                          input logic [DW-1:0] wd, input logic rv, input logic [AW-1:0] ra);
        logic st;
        build_expect(wv, wa, wd, rv, ra);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_addr = ra;
        lg_n = 0; lg_stalls = 0;
        for (int cyc = 0; cyc < 16; cyc++) begin
            #2;
            st = stall;
            if (bus_valid && lg_n < 8) begin
                lg_we[lg_n] = bus_we; lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_we ? bus_wdata : '0;
                lg_n++;
            end
            if (st) lg_stalls++;
            @(negedge clk);
            if (!st) break;
        end
        wr_valid = 1'b0; rd_valid = 1'b0;
        check(lg_stalls == ex_stalls, req, "stall cycles", lg_stalls, ex_stalls);
        check(lg_n == ex_n, req, "bus request count", lg_n, ex_n);
        for (int k = 0; k < 4; k++) begin
            if (k < ex_n && k < lg_n) begin
                check(lg_we[k] == ex_we[k] && lg_addr[k] == ex_addr[k] && lg_data[k] == ex_data[k],
                      req, "bus order entry", {lg_we[k], 9'h0, lg_addr[k]},
                      {ex_we[k], 9'h0, ex_addr[k]});
            end
        end
    endtask

    task automatic write_cfg(input logic [NR-1:0] v);
        cfg_wr = 1'b1; cfg_en = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        en_mirror = v;
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int sel;
        sel = int'($urandom % 5);
        case (sel)
            0: return 22'h000800 + AW'($urandom % 32'h800);
            1: return 22'h007000 + AW'($urandom % 32'h1000);
            2: return 22'h004000 + AW'($urandom % 32'h2000);
            default: return 22'h010000 + AW'($urandom % 32'h10000);
        endcase
    endfunction

    initial begin : watchdog
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [AW-1:0] wa, ra;
        void'($urandom(32'd4711));
        wr_valid = 1'b1; rd_valid = 1'b1; wr_addr = 22'h000900; rd_addr = 22'h000A00;
        repeat (3) @(negedge clk);
        #2;
        // R1: quiet during reset even with requests present
        check(!bus_valid && !stall, "R1", "reset outputs", {bus_valid, stall}, 0);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!bus_valid && !stall, "R1", "idle after reset", {bus_valid, stall}, 0);
        @(negedge clk);

        // R1 R6: all windows protected after reset
        run_op("R1", 1'b1, 22'h000900, 16'hA001, 1'b1, 22'h020000);
        run_op("R2", 1'b1, 22'h012345, 16'hBEEF, 1'b0, '0);
        run_op("R2", 1'b0, '0, '0, 1'b1, 22'h000810);
        run_op("R3", 1'b1, 22'h011000, 16'h1234, 1'b1, 22'h012000);
        run_op("R4", 1'b1, 22'h007FFF, 16'h5555, 1'b1, 22'h013000);
        // R6: read address alone in window 2 protects the pair
        run_op("R6", 1'b1, 22'h013000, 16'h6666, 1'b1, 22'h005FFF);
        run_op("R6", 1'b1, 22'h003FFF, 16'h6767, 1'b1, 22'h006000);
        run_op("R5", 1'b1, 22'h01ABCD, 16'h7777, 1'b1, 22'h01ABCD);
        run_op("R4", 1'b1, 22'h000FFF, 16'h7878, 1'b1, 22'h000FFF);
        // R7: disable window 1, its pairs become reordered
        write_cfg(3'b101);
        run_op("R7", 1'b1, 22'h007010, 16'h8888, 1'b1, 22'h007020);
        run_op("R7", 1'b1, 22'h007010, 16'h8989, 1'b1, 22'h000820);
        write_cfg(3'b000);
        run_op("R7", 1'b1, 22'h004100, 16'h9999, 1'b1, 22'h000900);
        write_cfg(3'b111);
        run_op("R7", 1'b1, 22'h004100, 16'h9A9A, 1'b1, 22'h010000);

        // R8 and all orderings under random stimulus
        for (int n = 0; n < 600; n++) begin
            int kind;
            if ($urandom % 25 == 0) write_cfg(NR'($urandom));
            wa = pick_addr();
            ra = ($urandom % 5 == 0) ? wa : pick_addr();
            kind = int'($urandom % 6);
            run_op("R8", kind != 1, wa, DW'($urandom), kind != 0, ra);
            if ($urandom % 3 == 0) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule